// File: doc/BRIEF.md
# Flash Command Status Register

This block is the status and command-launch register of a flash memory controller. Software sees one 8-bit register. It holds a command-complete flag, three sticky error flags and one read-only result bit. Software starts a command by writing one to the complete flag. The complete flag then stays low while the controller works. When the controller finishes, or rejects the command, the flag goes high again.

The controller side drives single-cycle event pulses into the block: end of post-reset initialisation, command done (with a result bit), illegal command or sequence, protection violation, emulated-EEPROM record written, and a read of the array. An access error or protection violation that is still pending blocks every new launch and every emulated-EEPROM RAM write until software clears it. A read of the array while a command is running raises the collision flag.

A level interrupt follows the complete flag, gated by an enable input. All control and status pins are plain signals with no handshake. A launch or EEPROM-write acceptance appears on its pulse output in the same cycle as the request.

Top module: `flash_cmd_stat`

## Requirements
- R1: After reset the register reads 0x00 and the interrupt is low. The complete flag (bit 7) rises in the cycle after an initialisation pulse. A launch write before that is rejected: no launch pulse, and the register stays 0x00.
- R2: Read layout: bit 7 complete flag, bit 6 read-collision flag, bit 5 access-error flag, bit 4 protection-violation flag, bit 0 command result. Bits 3 to 1 always read zero.
- R3: A write with bit 7 set, while the complete flag is 1 and bits 5 and 4 are 0, is accepted. It gives a launch pulse in the same cycle, and the complete flag reads 0 from the next cycle until the controller reports completion or a violation.
- R4: A launch write is rejected while the complete flag is 0 or while bit 5 or bit 4 is set. It gives no pulse and leaves the complete flag unchanged. Error clears carried by the same write still take effect.
- R5: Writing one to bit 6, 5 or 4 clears that flag. Writing zero has no effect. Writes to bits 3 to 0 change nothing.
- R6: An array read while the complete flag is 0 sets bit 6 in the next cycle. An array read while the complete flag is 1 leaves bit 6 unchanged.
- R7: An access-violation pulse sets bit 5, and a protection-violation pulse sets bit 4. Each also sets the complete flag in the next cycle.
- R8: An EEPROM RAM write request is accepted only while EEPROM-ready is high, the complete flag is 1 and bits 5 and 4 are 0. Acceptance gives a same-cycle pulse and clears the complete flag. A record-done pulse sets the flag again.
- R9: A hardware set of a flag wins over a software clear of that flag in the same cycle.
- R10: A command-done pulse sets the complete flag and latches the result input into bit 0. An accepted launch clears bit 0.
- R11: The interrupt output is high exactly while the complete flag is 1 and the interrupt enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Level interrupt |
| init_done_i | input | 1 | Post-reset initialisation finished (pulse) |
| cmd_launch_o | output | 1 | Command accepted and started (pulse) |
| cmd_done_i | input | 1 | Command completed (pulse) |
| cmd_result_i | input | 1 | Result bit, valid with cmd_done_i |
| acc_viol_i | input | 1 | Illegal command or sequence (pulse) |
| prot_viol_i | input | 1 | Protected-region violation (pulse) |
| flash_rd_i | input | 1 | Read of the flash array this cycle |
| ee_ready_i | input | 1 | Emulated-EEPROM mode enabled and ready |
| ee_wr_i | input | 1 | Write request to the EEPROM RAM |
| ee_wr_ok_o | output | 1 | EEPROM RAM write accepted (pulse) |
| ee_rec_done_i | input | 1 | EEPROM record written (pulse) |

## Verification
The assertions assume that the controller gives completion, violation and record-done pulses only for work it actually has in progress. They also assume each event lasts one cycle. The bench table keeps to this: every done, violation or record pulse follows an accepted launch or EEPROM write, or the initialisation step. Collision and set-versus-clear cases are the only ones where events and writes meet in the same cycle, and those are exactly the cases that R6 and R9 define.

// File: rtl/flstat_pkg.sv
package flstat_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_ERR  = 3;
  localparam int CMPL_BIT = 7;
  localparam int RSLT_BIT = 0;

  typedef enum int {ERR_RCOL = 0, ERR_AERR = 1, ERR_PVIO = 2} err_idx_e;

  function automatic int err_pos(input int idx);
    case (idx)
      ERR_RCOL: return 6;
      ERR_AERR: return 5;
      default:  return 4;
    endcase
  endfunction
endpackage

// File: rtl/flstat_gate.sv
module flstat_gate
  import flstat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmpl_i,
  input  logic [NUM_ERR-1:0] err_i,
  input  logic               launch_req_i,
  input  logic               ee_wr_i,
  input  logic               ee_ready_i,
  output logic               cmd_start_o,
  output logic               ee_accept_o
);
  logic blocked;

  always_comb begin
    blocked     = err_i[ERR_AERR] | err_i[ERR_PVIO];
    cmd_start_o = launch_req_i & cmpl_i & ~blocked;
    ee_accept_o = ee_wr_i & ee_ready_i & cmpl_i & ~blocked & ~cmd_start_o;
  end

  // R4
  busy_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmpl_i |-> !cmd_start_o && !ee_accept_o);
  // R8
  err_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i[ERR_AERR] || err_i[ERR_PVIO]) |-> !ee_accept_o && !cmd_start_o);
endmodule

// File: rtl/flstat_err_bank.sv
module flstat_err_bank
  import flstat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] set_i,
  input  logic [NUM_ERR-1:0] clr_i,
  output logic [NUM_ERR-1:0] flag_o
);
  for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
    logic flag_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[g]) flag_q <= 1'b1;
      else if (clr_i[g]) flag_q <= 1'b0;
    end

    assign flag_o[g] = flag_q;

    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
    // R5
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] && !set_i[g] |=> !flag_o[g]);
    // R5
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[g] && !clr_i[g] |=> flag_o[g]);
  end
endmodule

// File: rtl/flstat_cmpl.sv
module flstat_cmpl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  input  logic cmd_done_i,
  input  logic cmd_result_i,
  input  logic viol_i,
  input  logic ee_rec_done_i,
  input  logic cmd_start_i,
  input  logic ee_accept_i,
  output logic cmpl_o,
  output logic rslt_o
);
  logic cmpl_q, rslt_q, hw_set, sw_clr;

  always_comb begin
    hw_set = init_done_i | cmd_done_i | viol_i | ee_rec_done_i;
    sw_clr = cmd_start_i | ee_accept_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmpl_q <= 1'b0;
    else if (hw_set) cmpl_q <= 1'b1;
    else if (sw_clr) cmpl_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rslt_q <= 1'b0;
    else if (cmd_done_i)  rslt_q <= cmd_result_i;
    else if (cmd_start_i) rslt_q <= 1'b0;
  end

  assign cmpl_o = cmpl_q;
  assign rslt_o = rslt_q;

  // R3
  launch_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_i && !hw_set |=> !cmpl_o);
  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmpl_o && !hw_set |=> !cmpl_o);
  // R10
  result_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i |=> cmpl_o && (rslt_o == $past(cmd_result_i)));
  // R10
  result_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_i && !cmd_done_i |=> !rslt_o);
endmodule

// File: rtl/flash_cmd_stat.sv
module flash_cmd_stat
  import flstat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             irq_en_i,
  output logic             irq_o,
  input  logic             init_done_i,
  output logic             cmd_launch_o,
  input  logic             cmd_done_i,
  input  logic             cmd_result_i,
  input  logic             acc_viol_i,
  input  logic             prot_viol_i,
  input  logic             flash_rd_i,
  input  logic             ee_ready_i,
  input  logic             ee_wr_i,
  output logic             ee_wr_ok_o,
  input  logic             ee_rec_done_i
);
  localparam int RSV_LO = RSLT_BIT;
  localparam int RSV_HI = 3;

  logic               cmpl, rslt, cmd_start, ee_accept;
  logic [NUM_ERR-1:0] err_flag, err_set, err_clr;

  always_comb begin
    err_set           = '0;
    err_set[ERR_RCOL] = flash_rd_i & ~cmpl;
    err_set[ERR_AERR] = acc_viol_i;
    err_set[ERR_PVIO] = prot_viol_i;
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_clr
    assign err_clr[g] = wr_en_i & wr_data_i[err_pos(g)];
  end

  flstat_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmpl_i       (cmpl),
    .err_i        (err_flag),
    .launch_req_i (wr_en_i & wr_data_i[CMPL_BIT]),
    .ee_wr_i      (ee_wr_i),
    .ee_ready_i   (ee_ready_i),
    .cmd_start_o  (cmd_start),
    .ee_accept_o  (ee_accept)
  );

  flstat_err_bank u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (err_clr),
    .flag_o (err_flag)
  );

  flstat_cmpl u_cmpl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .init_done_i   (init_done_i),
    .cmd_done_i    (cmd_done_i),
    .cmd_result_i  (cmd_result_i),
    .viol_i        (acc_viol_i | prot_viol_i),
    .ee_rec_done_i (ee_rec_done_i),
    .cmd_start_i   (cmd_start),
    .ee_accept_i   (ee_accept),
    .cmpl_o        (cmpl),
    .rslt_o        (rslt)
  );

  always_comb begin
    rd_data_o                       = '0;
    rd_data_o[CMPL_BIT]             = cmpl;
    rd_data_o[err_pos(ERR_RCOL)]    = err_flag[ERR_RCOL];
    rd_data_o[err_pos(ERR_AERR)]    = err_flag[ERR_AERR];
    rd_data_o[err_pos(ERR_PVIO)]    = err_flag[ERR_PVIO];
    rd_data_o[RSLT_BIT]             = rslt;
  end

  assign irq_o        = cmpl & irq_en_i;
  assign cmd_launch_o = cmd_start;
  assign ee_wr_ok_o   = ee_accept;

  // R5
  reserved_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (|wr_data_i[RSV_HI:RSV_LO]) && (wr_data_i[REG_W-1:RSV_HI+1] == '0)
    && !(init_done_i || cmd_done_i || acc_viol_i || prot_viol_i || flash_rd_i
         || ee_wr_i || ee_rec_done_i)
    |=> $stable(rd_data_o));
  // R6
  collision_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_rd_i && cmpl && !wr_en_i && !err_flag[ERR_RCOL] |=> !rd_data_o[6]);
  // R7
  viol_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_viol_i || prot_viol_i) |=> rd_data_o[CMPL_BIT]);
endmodule

// File: tb/test_flash_cmd_stat.sv
`timescale 1ns/1ps
module test_flash_cmd_stat;
  typedef struct packed {
    logic       wr;
    logic [7:0] wd;
    logic       init, done, res, acc, prot, frd, eerdy, eewr, rec, ien;
    logic       xl, xe;
    logic [7:0] xs;
    logic       xi;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b1,8'h80,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00,1'b0, 4'd1 },  // R1 launch before init
    '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h80,1'b0, 4'd1 },  // R1 init
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h80,1'b1, 4'd11},  // R11
    '{1'b1,8'h80,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,8'h00,1'b0, 4'd3 },  // R3
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h40,1'b0, 4'd6 },  // R6
    '{1'b1,8'h80,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h40,1'b0, 4'd4 },  // R4 busy
    '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'hC1,1'b1, 4'd10},  // R10
    '{1'b1,8'h40,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h81,1'b1, 4'd5 },  // R5
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h81,1'b1, 4'd6 },  // R6 idle read
    '{1'b1,8'h0F,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h81,1'b1, 4'd2 },  // R2 reserved
    '{1'b1,8'h80,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,8'h00,1'b0, 4'd10},  // R10 clear
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'hA0,1'b1, 4'd7 },  // R7
    '{1'b1,8'h80,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'hA0,1'b1, 4'd4 },  // R4 error
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0,8'hA0,1'b1, 4'd8 },  // R8 blocked
    '{1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'hA0,1'b1, 4'd5 },  // R5 zero
    '{1'b1,8'hA0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h80,1'b1, 4'd4 },  // R4 clear+launch
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b1,8'h00,1'b0, 4'd8 },  // R8 accept
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0,8'h80,1'b1, 4'd8 },  // R8 record
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b0,8'h80,1'b1, 4'd8 },  // R8 not ready
    '{1'b1,8'h80,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,8'h00,1'b0, 4'd3 },  // R3
    '{1'b1,8'h40,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h40,1'b0, 4'd9 },  // R9 collision
    '{1'b1,8'h40,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h00,1'b0, 4'd5 },  // R5
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h90,1'b1, 4'd7 },  // R7 prot
    '{1'b1,8'h10,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h90,1'b1, 4'd9 },  // R9
    '{1'b1,8'h10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h80,1'b1, 4'd5 },  // R5
    '{1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h80,1'b0, 4'd11}   // R11 off
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, init_done = 1'b0, cmd_done = 1'b0, cmd_res = 1'b0;
  logic       acc_v = 1'b0, prot_v = 1'b0, frd = 1'b0, ee_rdy = 1'b0, ee_wr = 1'b0;
  logic       rec_done = 1'b0, irq_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq, launch, ee_ok;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  flash_cmd_stat i_flash_cmd_stat (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .irq_en_i(irq_en), .irq_o(irq),
    .init_done_i(init_done), .cmd_launch_o(launch), .cmd_done_i(cmd_done),
    .cmd_result_i(cmd_res), .acc_viol_i(acc_v), .prot_viol_i(prot_v),
    .flash_rd_i(frd), .ee_ready_i(ee_rdy), .ee_wr_i(ee_wr),
    .ee_wr_ok_o(ee_ok), .ee_rec_done_i(rec_done)
  );

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    wr_en = v.wr; wr_data = v.wd; init_done = v.init; cmd_done = v.done;
    cmd_res = v.res; acc_v = v.acc; prot_v = v.prot; frd = v.frd;
    ee_rdy = v.eerdy; ee_wr = v.eewr; rec_done = v.rec; irq_en = v.ien;
  endtask

  task automatic step(input vec_t v);
    drive(v);
    #1;
    chk(tag(v.rq), "launch", {7'd0, launch}, {7'd0, v.xl});
    chk(tag(v.rq), "ee_ok", {7'd0, ee_ok}, {7'd0, v.xe});
    @(negedge clk);
    chk(tag(v.rq), "status", rd_data, v.xs);
    chk(tag(v.rq), "irq", {7'd0, irq}, {7'd0, v.xi});
  endtask

  function automatic vec_t idle(input logic ien);
    vec_t v = '0;
    v.ien = ien;
    return v;
  endfunction

  initial begin
    vec_t v;
    repeat (2) @(negedge clk);
    chk("R1", "reset status", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "no init yet", rd_data, 8'h00);
    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R10: done with result 0 leaves bit 0 clear
    v = idle(1'b1); v.wr = 1'b1; v.wd = 8'h80; v.xl = 1'b1; v.xs = 8'h00; v.rq = 4'd10; step(v);
    v = idle(1'b1); v.done = 1'b1; v.res = 1'b0; v.xs = 8'h80; v.xi = 1'b1; v.rq = 4'd10; step(v);
    // R1: reset while busy with a pending flag returns to 0x00
    v = idle(1'b1); v.wr = 1'b1; v.wd = 8'h80; v.xl = 1'b1; v.xs = 8'h00; v.rq = 4'd3; step(v);
    v = idle(1'b1); v.frd = 1'b1; v.xs = 8'h40; v.rq = 4'd6; step(v);
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset status", rd_data, 8'h00);
    chk("R1", "async reset irq", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    v = idle(1'b1); v.wr = 1'b1; v.wd = 8'h80; v.xs = 8'h00; v.rq = 4'd1; step(v);
    v = idle(1'b1); v.init = 1'b1; v.xs = 8'h80; v.xi = 1'b1; v.rq = 4'd1; step(v);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule